// File: doc/BRIEF.md
# Self-Programming Control Register Sequencer

This block holds the 8-bit control and status register that a small microcontroller core uses to drive self-programming of its program memory. The core writes the register over a narrow I/O bus. Setting the self-program-enable bit in the same write as exactly one command bit opens a short window that is counted in clock cycles. A store-program-memory (SPM) or load-program-memory (LPM) strobe from the core's decoder that arrives inside the window turns the armed command into a single-cycle command pulse toward the flash controller, or into a lock/fuse read select.

A window that passes with no qualifying strobe disarms itself and issues nothing. An issued flash operation keeps the register bits set until the flash controller's busy signal has risen and then fallen. A separate ready interrupt is requested while the register is idle and enabled, and it is held off by the global interrupt flag and by either busy input. A write of the read-enable bit while the core is filling the temporary page buffer produces a buffer-clear pulse.

The sequencer has six states. IDLE: no window is open. ARM_WRT, ARM_ERS and ARM_BLB: a window is open for page write, page erase or lock-bit set. OP_WAIT: a command has been issued and the block waits for busy to rise. OP_RUN: the block waits for busy to fall. The transitions are as follows:
- IDLE goes to ARM_x on a valid arming write.
- An ARM state goes to OP_WAIT on an SPM strobe.
- ARM_BLB goes to IDLE on an LPM strobe.
- Any ARM state goes to IDLE when its window expires.
- OP_WAIT goes to OP_RUN when busy is high.
- OP_RUN goes to IDLE when busy is low.

Top module: `spm_ctrl_seq`

## Requirements
- R1: After reset every register bit reads 0, all command pulses and buf_clear_o are low, and irq_o is low.
- R2: A read at I/O address 0x37 returns {irq-enable, 0, 0, read-enable, lock-set, page-write, page-erase, self-program-enable} from bit 7 down to bit 0. Bits 6 and 5 always read 0. Other addresses read 0, and writes to them have no effect.
- R3: A write in IDLE arms a window only when bit 0 is 1 and exactly one of bits 3, 2 and 1 is 1. In every other case bits 3 to 0 read back 0. Bits 7 and 4 always take the written value.
- R4: After a write that arms page write (0x05) or page erase (0x03), an spm_stb in any of the 4 cycles following the write edge drives page_write_o or page_erase_o high in that same cycle.
- R5: After a write that arms lock-set (0x09), an lpm_stb in any of the 3 following cycles drives cfg_rd_o high with cfg_sel_o equal to z0 (1 selects lock bits, 0 selects fuse bits), and the register returns to idle on the next edge. An spm_stb in that window drives lock_set_o instead.
- R6: If no qualifying strobe comes inside the window, bits 3 to 0 clear after the last window cycle and no pulse is produced. An lpm_stb does not qualify in a page-write or page-erase window.
- R7: After a command pulse, bit 0 and the command bit stay set until flash_busy has risen and then fallen. They clear on the edge at which flash_busy is sampled low.
- R8: A write at 0x37 with bit 4 set while buf_filling is high produces a one-cycle buf_clear_o pulse in the cycle after the write edge. With buf_filling low, no pulse is produced.
- R9: irq_o is high exactly when bit 7 is 1, gie is 1, bit 0 is 0, and both ee_busy and flash_busy are 0.
- R10: A write while a window or an operation is active changes only bits 7 and 4. Bits 3 to 0 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 6 | I/O register address |
| io_we | input | 1 | Register write enable |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data (combinational) |
| spm_stb | input | 1 | Store-program-memory instruction executing |
| lpm_stb | input | 1 | Load-program-memory instruction executing |
| z0 | input | 1 | Low bit of the Z pointer |
| gie | input | 1 | Global interrupt enable flag |
| ee_busy | input | 1 | EEPROM write in progress |
| flash_busy | input | 1 | Flash operation in progress |
| buf_filling | input | 1 | Temporary page buffer is being filled |
| page_write_o | output | 1 | Page write command pulse |
| page_erase_o | output | 1 | Page erase command pulse |
| lock_set_o | output | 1 | Lock-bit set command pulse |
| cfg_rd_o | output | 1 | Lock/fuse read pulse |
| cfg_sel_o | output | 1 | Lock (1) or fuse (0) select during cfg_rd_o |
| buf_clear_o | output | 1 | Temporary buffer clear pulse |
| irq_o | output | 1 | Ready interrupt request |

## Verification
Two sets of events can fall in the same cycle. The first is window expiry and strobe acceptance: the strobe-delay sweep places a strobe exactly on the last window cycle and one cycle after it. The strobe must win on the last cycle and must be refused one cycle later. The second is a register write with the read-enable bit set, made during buffer fill in the same cycle as an SPM strobe inside a page-write window. The bench expects the command pulse in that cycle, the buffer-clear pulse in the next cycle, and a readback in which the armed bits are unchanged while bit 4 is now set.

// File: rtl/spm_seq_pkg.sv
package spm_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM_WRT,
        ST_ARM_ERS,
        ST_ARM_BLB,
        ST_OP_WAIT,
        ST_OP_RUN
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_WRT,
        CMD_ERS,
        CMD_BLB
    } cmd_e;

    localparam int BIT_IE  = 7;
    localparam int BIT_RRE = 4;
    localparam int BIT_BLB = 3;
    localparam int BIT_WRT = 2;
    localparam int BIT_ERS = 1;
    localparam int BIT_EN  = 0;
endpackage

// File: rtl/spm_seq_wr_decode.sv
module spm_seq_wr_decode
    import spm_seq_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter int          DATA_W   = 8,
    parameter logic [5:0]  REG_ADDR = 6'h37
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_we,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              hit_wr,
    output cmd_e              arm_cmd
);
    logic [1:0] n_cmd;

    always_comb begin
        hit_wr  = io_we && (io_addr == ADDR_W'(REG_ADDR));
        n_cmd   = 2'(io_wdata[BIT_BLB]) + 2'(io_wdata[BIT_WRT]) + 2'(io_wdata[BIT_ERS]);
        arm_cmd = CMD_NONE;
        if (hit_wr && io_wdata[BIT_EN] && (n_cmd == 2'd1)) begin
            if (io_wdata[BIT_WRT])      arm_cmd = CMD_WRT;
            else if (io_wdata[BIT_ERS]) arm_cmd = CMD_ERS;
            else                        arm_cmd = CMD_BLB;
        end
    end
endmodule

// File: rtl/spm_seq_win_cnt.sv
module spm_seq_win_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/spm_seq_irq_gate.sv
module spm_seq_irq_gate (
    input  logic ie,
    input  logic gie,
    input  logic idle,
    input  logic ee_busy,
    input  logic flash_busy,
    output logic irq
);
    assign irq = ie && gie && idle && !ee_busy && !flash_busy;
endmodule

// File: rtl/spm_ctrl_seq.sv
module spm_ctrl_seq
    import spm_seq_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter int         DATA_W   = 8,
    parameter logic [5:0] REG_ADDR = 6'h37,
    parameter int         PGM_WIN  = 4,
    parameter int         LOCK_WIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_we,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              spm_stb,
    input  logic              lpm_stb,
    input  logic              z0,
    input  logic              gie,
    input  logic              ee_busy,
    input  logic              flash_busy,
    input  logic              buf_filling,
    output logic              page_write_o,
    output logic              page_erase_o,
    output logic              lock_set_o,
    output logic              cfg_rd_o,
    output logic              cfg_sel_o,
    output logic              buf_clear_o,
    output logic              irq_o
);
    localparam int WIN_MAX = (PGM_WIN > LOCK_WIN) ? PGM_WIN : LOCK_WIN;
    localparam int CNT_W   = $clog2(WIN_MAX + 1);

    seq_state_e state_q, state_nx;
    cmd_e       cmd_q, arm_cmd;
    logic       ie_q, rre_q, clr_q;
    logic       hit_wr, win_last, win_load, win_tick, idle;
    logic [CNT_W-1:0] win_len;

    spm_seq_wr_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .REG_ADDR(REG_ADDR)
    ) u_dec (
        .io_addr (io_addr),
        .io_we   (io_we),
        .io_wdata(io_wdata),
        .hit_wr  (hit_wr),
        .arm_cmd (arm_cmd)
    );

    assign idle     = (state_q == ST_IDLE);
    assign win_load = idle && (arm_cmd != CMD_NONE);
    assign win_len  = (arm_cmd == CMD_BLB) ? CNT_W'(LOCK_WIN) : CNT_W'(PGM_WIN);
    assign win_tick = (state_q == ST_ARM_WRT) || (state_q == ST_ARM_ERS) ||
                      (state_q == ST_ARM_BLB);

    spm_seq_win_cnt #(.CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (win_load),
        .load_val(win_len),
        .tick    (win_tick),
        .last    (win_last)
    );

    spm_seq_irq_gate u_irq (
        .ie        (ie_q),
        .gie       (gie),
        .idle      (idle),
        .ee_busy   (ee_busy),
        .flash_busy(flash_busy),
        .irq       (irq_o)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (arm_cmd)
                    CMD_WRT:  state_nx = ST_ARM_WRT;
                    CMD_ERS:  state_nx = ST_ARM_ERS;
                    CMD_BLB:  state_nx = ST_ARM_BLB;
                    default:  state_nx = ST_IDLE;
                endcase
            end
            ST_ARM_WRT, ST_ARM_ERS: begin
                if (spm_stb)       state_nx = ST_OP_WAIT;
                else if (win_last) state_nx = ST_IDLE;
            end
            ST_ARM_BLB: begin
                if (spm_stb)       state_nx = ST_OP_WAIT;
                else if (lpm_stb)  state_nx = ST_IDLE;
                else if (win_last) state_nx = ST_IDLE;
            end
            ST_OP_WAIT: if (flash_busy)  state_nx = ST_OP_RUN;
            ST_OP_RUN:  if (!flash_busy) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state and register bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NONE;
            ie_q    <= 1'b0;
            rre_q   <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (state_nx == ST_IDLE) cmd_q <= CMD_NONE;
            else if (idle)           cmd_q <= arm_cmd;
            if (hit_wr) begin
                ie_q  <= io_wdata[BIT_IE];
                rre_q <= io_wdata[BIT_RRE];
            end
            clr_q <= hit_wr && io_wdata[BIT_RRE] && buf_filling;
        end
    end

    // outputs
    always_comb begin
        page_write_o = 1'b0;
        page_erase_o = 1'b0;
        lock_set_o   = 1'b0;
        cfg_rd_o     = 1'b0;
        unique case (state_q)
            ST_ARM_WRT: page_write_o = spm_stb;
            ST_ARM_ERS: page_erase_o = spm_stb;
            ST_ARM_BLB: begin
                lock_set_o = spm_stb;
                cfg_rd_o   = lpm_stb && !spm_stb;
            end
            default: ;
        endcase
        cfg_sel_o   = cfg_rd_o && z0;
        buf_clear_o = clr_q;
        io_rdata    = '0;
        if (io_addr == ADDR_W'(REG_ADDR)) begin
            io_rdata[BIT_IE]  = ie_q;
            io_rdata[BIT_RRE] = rre_q;
            io_rdata[BIT_BLB] = (cmd_q == CMD_BLB);
            io_rdata[BIT_WRT] = (cmd_q == CMD_WRT);
            io_rdata[BIT_ERS] = (cmd_q == CMD_ERS);
            io_rdata[BIT_EN]  = !idle;
        end
    end
endmodule

// File: rtl/spm_ctrl_seq_chk.sv
module spm_ctrl_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] io_addr,
    input logic       io_we,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic       spm_stb,
    input logic       lpm_stb,
    input logic       z0,
    input logic       gie,
    input logic       ee_busy,
    input logic       flash_busy,
    input logic       buf_filling,
    input logic       page_write_o,
    input logic       page_erase_o,
    input logic       lock_set_o,
    input logic       cfg_rd_o,
    input logic       cfg_sel_o,
    input logic       buf_clear_o,
    input logic       irq_o
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata[6:5] == 2'b00); // R2

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({page_write_o, page_erase_o, lock_set_o, cfg_rd_o})); // R4

    AST_CMD_NEEDS_SPM: assert property (@(posedge clk) disable iff (!rst_n)
        (page_write_o || page_erase_o || lock_set_o) |-> spm_stb); // R4

    AST_CFG_NEEDS_LPM: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_o |-> lpm_stb); // R5

    AST_SEL_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel_o |-> (cfg_rd_o && z0)); // R5

    AST_CLR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clear_o |-> $past(io_we && io_addr == 6'h37 && io_wdata[4] && buf_filling)); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie && !ee_busy && !flash_busy)); // R9
endmodule

bind spm_ctrl_seq spm_ctrl_seq_chk chk_i (.*);

// File: tb/spm_ctrl_seq_tb_top.sv
module spm_ctrl_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_addr = 6'h37;
    logic       io_we = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       spm_stb = 1'b0, lpm_stb = 1'b0, z0 = 1'b0;
    logic       gie = 1'b0, ee_busy = 1'b0, flash_busy = 1'b0, buf_filling = 1'b0;
    logic       page_write_o, page_erase_o, lock_set_o, cfg_rd_o, cfg_sel_o;
    logic       buf_clear_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spm_ctrl_seq dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        io_addr  = a;
        io_wdata = d;
        io_we    = 1'b1;
        @(negedge clk);
        io_we    = 1'b0;
        io_addr  = 6'h37;
    endtask

    function automatic logic [3:0] pulses();
        return {page_write_o, page_erase_o, lock_set_o, cfg_rd_o};
    endfunction

    task automatic busy_cycle();
        flash_busy = 1'b1;
        repeat (3) @(negedge clk);
        chk(io_rdata[0] == 1'b1, "R7 held while busy", io_rdata, 1);
        flash_busy = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        gie = 1'b1;
        #1;
        // R1 reset state
        chk(io_rdata == 8'h00, "R1 reset rdata", io_rdata, 0);
        chk(pulses() == 4'b0 && !buf_clear_o && !irq_o, "R1 reset outputs",
            {pulses(), buf_clear_o, irq_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 other address
        wr(6'h36, 8'hFF);
        io_addr = 6'h36; #1;
        chk(io_rdata == 8'h00, "R2 other addr read", io_rdata, 0);
        io_addr = 6'h37; #1;
        chk(io_rdata == 8'h00, "R2 other addr write ignored", io_rdata, 0);

        // R3/R2/R9 sweep of all write values
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            logic       arm;
            logic [7:0] e1, e2;
            b   = 8'(v);
            arm = b[0] && ($countones(b[3:1]) == 1);
            e2  = {b[7], 2'b00, b[4], 4'b0000};
            e1  = e2 | (arm ? {4'b0000, b[3:1], 1'b1} : 8'h00);
            wr(6'h37, b);
            #1;
            chk(io_rdata == e1, "R3 arm readback", io_rdata, e1);
            chk(irq_o == (b[7] && !arm), "R9 irq after write", irq_o, b[7] && !arm);
            repeat (5) @(negedge clk);
            #1;
            chk(io_rdata == e2, "R6 idle readback", io_rdata, e2);
        end
        wr(6'h37, 8'h00);

        // R4/R5/R6/R7 window sweep
        for (int c = 0; c < 3; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int d = 1; d <= 6; d++) begin
                    logic [7:0] cmdv;
                    int         win;
                    logic       hit;
                    logic [3:0] ep;
                    cmdv = (c == 0) ? 8'h05 : (c == 1) ? 8'h03 : 8'h09;
                    win  = (c == 2) ? 3 : 4;
                    hit  = (d <= win) && (s == 0 || c == 2);
                    ep   = 4'b0;
                    if (hit) begin
                        if (c == 0)      ep = 4'b1000;
                        else if (c == 1) ep = 4'b0100;
                        else if (s == 0) ep = 4'b0010;
                        else             ep = 4'b0001;
                    end
                    wr(6'h37, cmdv);
                    repeat (d - 1) @(negedge clk);
                    z0 = d[0];
                    if (s == 0) spm_stb = 1'b1; else lpm_stb = 1'b1;
                    #1;
                    chk(pulses() == ep, "R4 R5 R6 window pulse", pulses(), ep);
                    if (ep[0])
                        chk(cfg_sel_o == z0, "R5 cfg select", cfg_sel_o, z0);
                    @(negedge clk);
                    spm_stb = 1'b0;
                    lpm_stb = 1'b0;
                    #1;
                    if (hit && s == 0) begin
                        chk(io_rdata == cmdv, "R7 bits hold after issue", io_rdata, cmdv);
                        busy_cycle();
                        #1;
                        chk(io_rdata == 8'h00, "R7 clear after busy", io_rdata, 0);
                    end else if (hit) begin
                        chk(io_rdata == 8'h00, "R5 idle after read", io_rdata, 0);
                    end else begin
                        repeat (6) @(negedge clk);
                        #1;
                        chk(io_rdata == 8'h00, "R6 expired", io_rdata, 0);
                    end
                end
            end
        end

        // R9 interrupt gating
        wr(6'h37, 8'h80); #1;
        chk(irq_o == 1'b1, "R9 irq enabled", irq_o, 1);
        gie = 1'b0; #1;
        chk(irq_o == 1'b0, "R9 gie low", irq_o, 0);
        gie = 1'b1; ee_busy = 1'b1; #1;
        chk(irq_o == 1'b0, "R9 ee busy", irq_o, 0);
        ee_busy = 1'b0; flash_busy = 1'b1; #1;
        chk(irq_o == 1'b0, "R9 flash busy", irq_o, 0);
        flash_busy = 1'b0;
        @(negedge clk);
        wr(6'h37, 8'h85); #1;
        chk(irq_o == 1'b0, "R9 armed blocks irq", irq_o, 0);
        spm_stb = 1'b1;
        @(negedge clk);
        spm_stb = 1'b0;
        busy_cycle(); #1;
        chk(irq_o == 1'b1, "R9 irq after completion", irq_o, 1);
        chk(io_rdata == 8'h80, "R7 done readback", io_rdata, 8'h80);

        // R8 buffer clear
        buf_filling = 1'b1;
        wr(6'h37, 8'h10); #1;
        chk(buf_clear_o == 1'b1, "R8 clear pulse", buf_clear_o, 1);
        @(negedge clk); #1;
        chk(buf_clear_o == 1'b0, "R8 pulse one cycle", buf_clear_o, 0);
        buf_filling = 1'b0;
        wr(6'h37, 8'h10); #1;
        chk(buf_clear_o == 1'b0, "R8 no fill no pulse", buf_clear_o, 0);

        // R10 write during window, concurrent with strobe and clear
        wr(6'h37, 8'h05);
        wr(6'h37, 8'h03); #1;
        chk(io_rdata == 8'h05, "R10 write in window keeps cmd", io_rdata, 8'h05);
        io_wdata = 8'h10; io_we = 1'b1; buf_filling = 1'b1; spm_stb = 1'b1; #1;
        chk(page_write_o == 1'b1, "R4 strobe with write", page_write_o, 1);
        @(negedge clk);
        io_we = 1'b0; buf_filling = 1'b0; spm_stb = 1'b0; #1;
        chk(buf_clear_o == 1'b1, "R8 clear with strobe", buf_clear_o, 1);
        chk(io_rdata == 8'h15, "R10 readback after concurrent", io_rdata, 8'h15);
        busy_cycle(); #1;
        chk(io_rdata == 8'h10, "R7 final idle", io_rdata, 8'h10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule